// File: doc/BRIEF.md
# Rolling Shutter Exposure Scheduler

This block schedules pixel exposure for an image sensor with an electronic shutter. Two capture modes are supported. In continuous (video) mode every row must see the same exposure, so each row's reset is staggered. A reset pointer runs a fixed number of row times ahead of the row being read out. The block emits that row's address with a one-cycle valid strobe on every row-start event. The rows near the top of a frame wrap back into the previous frame's tail, so they pick up the extra frame-boundary time automatically.

In single-frame (still) mode all pixels integrate together. A one-cycle trigger starts a global exposure counter, which counts master clocks in units of 16. When it expires the block emits a single global transfer pulse, and the cycle after that an exposure-done flag. It then follows the row readout and accepts no new trigger until the whole frame has been read. Configuration (mode, frame row count, continuous row offset, global tick count) is sampled only on the frame-start strobe, so exposure never changes inside a frame.

Top module: `rsexp_sched`

## Requirements
- R1: After reset, resetRowValid, globalXfer and exposureDone are 0 and resetRowAddr is 0.
- R2: With the latched mode continuous (captureMode 0), each rowStart yields resetRowValid high for exactly the next cycle. resetRowAddr = (readout row + contRows + 1) mod frameRows. The readout row is 0 for the first rowStart after frameStart, then rises by one per rowStart and wraps to 0 after frameRows-1.
- R3: A contRows value of frameRows or more saturates: the reset address then equals the readout row, giving a full-frame exposure.
- R4: No reset strobe is issued when the computed row is at or above the physical row count PHYS_ROWS; resetRowValid stays 0 for that row start.
- R5: captureMode, frameRows, contRows and globalTicks take effect only at frameStart; changes between frame starts do not alter the strobes or the exposure length.
- R6: When frameStart and rowStart arrive in the same cycle, frameStart wins. No reset strobe is issued, and the next rowStart reads row 0.
- R7: With the latched mode single (captureMode 1), a trigger sampled in idle starts an exposure. globalXfer is high for one cycle, max(globalTicks,1)×16 cycles after the trigger cycle.
- R8: exposureDone is high for exactly the one cycle following globalXfer.
- R9: After globalXfer the block counts frameRows rowStart events as readout. Triggers during exposure or readout are ignored, and a trigger is accepted again only after the last readout row start.
- R10: In single mode no reset strobes are issued; in continuous mode triggers never produce globalXfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Frame-start strobe, samples configuration |
| rowStart | input | 1 | Row-start strobe, one per readout row |
| captureMode | input | 1 | 0 continuous, 1 single-frame |
| frameRows | input | ROW_W | Rows per virtual frame (0 treated as 1) |
| contRows | input | ROW_W | Continuous-mode exposure in row times minus one |
| globalTicks | input | SINT_W | Single-frame exposure in units of 16 clocks |
| trigger | input | 1 | Single-frame capture request |
| resetRowAddr | output | ROW_W | Row to reset |
| resetRowValid | output | 1 | One-cycle strobe qualifying resetRowAddr |
| globalXfer | output | 1 | One-cycle global charge transfer pulse |
| exposureDone | output | 1 | One-cycle flag after the transfer |

## Verification
The continuous path is swept over every frame length from 3 to 13 rows and every offset up to two past the frame length, for two full frames each. This separates the plain modulo wrap from saturation and, with a 10-row physical limit, from suppression. The single path runs every tick count from 0 to 15, so the zero-clamp and the 16-cycle scaling are both seen. Retriggers are injected mid-exposure and mid-readout, and configuration is changed between frame starts; a block that restarted, aborted or resampled early would shift the measured cycle counts.

// File: rtl/rsexp_pkg.sv
package rsexp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_EXPOSE  = 2'd1,
    ST_READOUT = 2'd2
  } shState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchCfg;  // sample configuration
    logic rowClear;  // readout row back to 0
    logic rowStep;   // continuous row start: emit reset, advance
    logic expClear;  // start global exposure count
    logic expStep;   // advance global exposure count
    logic rdClear;   // start single-frame readout count
    logic rdStep;    // one single-frame readout row done
  } ctlStrobe_t;

endpackage

// File: rtl/rsexp_path.sv
module rsexp_path
  import rsexp_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int PHYS_ROWS = 480,
  parameter int SINT_W    = 20,
  parameter int TICK_LOG  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobes,
  input  logic [ROW_W-1:0]  frameRows,
  input  logic [ROW_W-1:0]  contRows,
  input  logic              captureMode,
  input  logic [SINT_W-1:0] globalTicks,
  output logic              modeLat,
  output logic              expHit,
  output logic              rdLast,
  output logic [ROW_W-1:0]  resetRowAddr,
  output logic              resetRowValid
);

  localparam int CNT_W = SINT_W + TICK_LOG;
  localparam int SUM_W = ROW_W + 1;

  logic [ROW_W-1:0]  rowsLat, offsetLat, readRow, rdCnt;
  logic [SINT_W-1:0] ticksLat;
  logic [CNT_W-1:0]  expCnt, expTarget;

  // Configuration sampling
  logic [ROW_W-1:0] rowsEff, offsetNext;
  always_comb begin
    rowsEff    = (frameRows == '0) ? ROW_W'(1) : frameRows;
    offsetNext = (contRows >= rowsEff) ? rowsEff : contRows + ROW_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowsLat   <= ROW_W'(1);
      offsetLat <= ROW_W'(1);
      ticksLat  <= '0;
      modeLat   <= 1'b0;
    end else if (strobes.latchCfg) begin
      rowsLat   <= rowsEff;
      offsetLat <= offsetNext;
      ticksLat  <= globalTicks;
      modeLat   <= captureMode;
    end
  end

  // Readout row pointer and staggered reset pointer
  logic [SUM_W-1:0] rowSum;
  logic [ROW_W-1:0] rowWrap;
  logic             inPhys;
  always_comb begin
    rowSum  = {1'b0, readRow} + {1'b0, offsetLat};
    rowWrap = ROW_W'((rowSum >= {1'b0, rowsLat}) ? rowSum - {1'b0, rowsLat} : rowSum);
  end

  generate
    if (PHYS_ROWS >= (1 << ROW_W)) begin : g_fullArray
      assign inPhys = 1'b1;
    end else begin : g_clipArray
      assign inPhys = (rowWrap < ROW_W'(PHYS_ROWS));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readRow       <= '0;
      resetRowAddr  <= '0;
      resetRowValid <= 1'b0;
    end else begin
      resetRowValid <= 1'b0;
      if (strobes.rowClear) begin
        readRow <= '0;
      end else if (strobes.rowStep) begin
        readRow       <= (readRow == rowsLat - ROW_W'(1)) ? '0 : readRow + ROW_W'(1);
        resetRowAddr  <= rowWrap;
        resetRowValid <= inPhys;
      end
    end
  end

  // Global exposure counter (cycles since trigger, inclusive)
  logic [SINT_W-1:0] ticksEff;
  assign ticksEff = (ticksLat == '0) ? SINT_W'(1) : ticksLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expCnt    <= '0;
      expTarget <= '0;
    end else if (strobes.expClear) begin
      expCnt    <= CNT_W'(1);
      expTarget <= {ticksEff, {TICK_LOG{1'b0}}};
    end else if (strobes.expStep) begin
      expCnt <= expCnt + CNT_W'(1);
    end
  end
  assign expHit = (expCnt == expTarget);

  // Single-frame readout row counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdCnt <= '0;
    else if (strobes.rdClear) rdCnt <= '0;
    else if (strobes.rdStep)  rdCnt <= rdCnt + ROW_W'(1);
  end
  assign rdLast = (rdCnt == rowsLat - ROW_W'(1));

  // Assertions
  p_phys_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    resetRowValid |-> (int'(resetRowAddr) < PHYS_ROWS));
  p_read_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    readRow < rowsLat);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rowStep |=> $stable(resetRowAddr));
  p_no_reset_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    resetRowValid |-> !modeLat);

endmodule

// File: rtl/rsexp_ctrl.sv
module rsexp_ctrl
  import rsexp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       rowStart,
  input  logic       trigger,
  input  logic       modeLat,
  input  logic       expHit,
  input  logic       rdLast,
  output ctlStrobe_t strobes,
  output logic       globalXfer,
  output logic       exposureDone
);

  shState_t state, stateNext;

  always_comb begin
    strobes          = '0;
    strobes.latchCfg = frameStart;
    strobes.rowClear = frameStart;
    strobes.rowStep  = rowStart && !frameStart && !modeLat;
    strobes.expClear = (state == ST_IDLE) && modeLat && trigger;
    strobes.expStep  = (state == ST_EXPOSE) && !expHit;
    strobes.rdClear  = (state == ST_EXPOSE) && expHit;
    strobes.rdStep   = (state == ST_READOUT) && rowStart;

    stateNext = state;
    unique case (state)
      ST_IDLE:    if (strobes.expClear) stateNext = ST_EXPOSE;
      ST_EXPOSE:  if (expHit) stateNext = ST_READOUT;
      ST_READOUT: if (rowStart && rdLast) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      globalXfer   <= 1'b0;
      exposureDone <= 1'b0;
    end else begin
      state        <= stateNext;
      globalXfer   <= strobes.rdClear;
      exposureDone <= globalXfer;
    end
  end

  // Assertions
  p_xfer_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    globalXfer |=> !globalXfer);
  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    globalXfer |=> exposureDone);
  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    exposureDone |-> $past(globalXfer));
  p_no_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXPOSE) |=> (state != ST_IDLE));
  p_xfer_state_r9: assert property (@(posedge clk) disable iff (!rstN)
    globalXfer |-> (state == ST_READOUT));

endmodule

// File: rtl/rsexp_sched.sv
module rsexp_sched
  import rsexp_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int PHYS_ROWS = 480,
  parameter int SINT_W    = 20,
  parameter int TICK_LOG  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              rowStart,
  input  logic              captureMode,
  input  logic [ROW_W-1:0]  frameRows,
  input  logic [ROW_W-1:0]  contRows,
  input  logic [SINT_W-1:0] globalTicks,
  input  logic              trigger,
  output logic [ROW_W-1:0]  resetRowAddr,
  output logic              resetRowValid,
  output logic              globalXfer,
  output logic              exposureDone
);

  ctlStrobe_t strobes;
  logic       modeLat, expHit, rdLast;

  rsexp_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameStart   (frameStart),
    .rowStart     (rowStart),
    .trigger      (trigger),
    .modeLat      (modeLat),
    .expHit       (expHit),
    .rdLast       (rdLast),
    .strobes      (strobes),
    .globalXfer   (globalXfer),
    .exposureDone (exposureDone)
  );

  rsexp_path #(
    .ROW_W     (ROW_W),
    .PHYS_ROWS (PHYS_ROWS),
    .SINT_W    (SINT_W),
    .TICK_LOG  (TICK_LOG)
  ) i_path (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .frameRows     (frameRows),
    .contRows      (contRows),
    .captureMode   (captureMode),
    .globalTicks   (globalTicks),
    .modeLat       (modeLat),
    .expHit        (expHit),
    .rdLast        (rdLast),
    .resetRowAddr  (resetRowAddr),
    .resetRowValid (resetRowValid)
  );

endmodule

// File: tb/test_rsexp_sched.sv
module test_rsexp_sched;

  localparam int ROW_W = 4;
  localparam int PHYS  = 10;
  localparam int SW    = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, rowStart = 1'b0, captureMode = 1'b0, trigger = 1'b0;
  logic [ROW_W-1:0] frameRows = '0, contRows = '0;
  logic [SW-1:0] globalTicks = '0;
  logic [ROW_W-1:0] resetRowAddr;
  logic resetRowValid, globalXfer, exposureDone;

  int total = 0, failed = 0;
  int xferSeen = 0, validSeen = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rsexp_sched #(.ROW_W(ROW_W), .PHYS_ROWS(PHYS), .SINT_W(SW), .TICK_LOG(4)) i_rsexp_sched (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .rowStart(rowStart),
    .captureMode(captureMode), .frameRows(frameRows), .contRows(contRows),
    .globalTicks(globalTicks), .trigger(trigger), .resetRowAddr(resetRowAddr),
    .resetRowValid(resetRowValid), .globalXfer(globalXfer), .exposureDone(exposureDone)
  );

  always @(negedge clk) begin
    if (globalXfer) xferSeen++;
    if (resetRowValid) validSeen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseFrame();
    @(negedge clk) frameStart = 1'b1;
    @(negedge clk) frameStart = 1'b0;
  endtask

  // Outputs sampled at the negedge right after the registering edge
  task automatic pulseRow();
    @(negedge clk) rowStart = 1'b1;
    @(negedge clk) rowStart = 1'b0;
  endtask

  function automatic int expRow(int rows, int cint, int rd);
    int off;
    off = (cint >= rows) ? rows : cint + 1;
    return (rd + off) % rows;
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      failed++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  %0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    int vBase, xBase, k, n, e;
    repeat (3) @(negedge clk);
    // R1
    chk(resetRowValid == 0 && globalXfer == 0 && exposureDone == 0 && resetRowAddr == 0,
        "R1 reset state", int'(resetRowAddr), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R3/R4 sweep, R10 trigger ignored in continuous mode
    captureMode = 1'b0;
    xBase = xferSeen;
    for (int rows = 3; rows <= 13; rows++) begin
      for (int cint = 0; cint <= rows + 1; cint++) begin
        frameRows = ROW_W'(rows);
        contRows  = ROW_W'(cint);
        pulseFrame();
        for (int kk = 0; kk < 2 * rows; kk++) begin
          if (kk == 1) trigger = 1'b1;
          pulseRow();
          trigger = 1'b0;
          e = expRow(rows, cint, kk % rows);
          if (e >= PHYS) begin
            chk(resetRowValid == 0, "R4 suppressed row", int'(resetRowValid), 0);
          end else begin
            chk(resetRowValid == 1, (cint >= rows) ? "R3 saturated valid" : "R2 valid",
                int'(resetRowValid), 1);
            chk(int'(resetRowAddr) == e, (cint >= rows) ? "R3 saturated addr" : "R2 addr",
                int'(resetRowAddr), e);
          end
          if (kk == 0) begin
            @(negedge clk);
            chk(resetRowValid == 0, "R2 strobe width", int'(resetRowValid), 0);
          end
        end
      end
    end
    repeat (20) @(negedge clk);
    chk(xferSeen == xBase, "R10 trigger in continuous", xferSeen - xBase, 0);

    // R5 latching of continuous config
    frameRows = 4'd8; contRows = 4'd2;
    pulseFrame();
    pulseRow();
    chk(int'(resetRowAddr) == 3 && resetRowValid, "R5 before change", int'(resetRowAddr), 3);
    contRows = 4'd5; frameRows = 4'd12; captureMode = 1'b1;
    pulseRow();
    chk(int'(resetRowAddr) == 4 && resetRowValid, "R5 ignored mid-frame", int'(resetRowAddr), 4);
    captureMode = 1'b0;
    pulseFrame();
    pulseRow();
    chk(int'(resetRowAddr) == 6 && resetRowValid, "R5 taken at frame start", int'(resetRowAddr), 6);

    // R6 frame start wins over coincident row start
    pulseRow();
    @(negedge clk) begin frameStart = 1'b1; rowStart = 1'b1; end
    @(negedge clk) begin frameStart = 1'b0; rowStart = 1'b0; end
    chk(resetRowValid == 0, "R6 no strobe on coincidence", int'(resetRowValid), 0);
    pulseRow();
    chk(int'(resetRowAddr) == 6 && resetRowValid, "R6 restarts at row 0", int'(resetRowAddr), 6);

    // R7/R8/R9/R10 single-frame sweep
    captureMode = 1'b1;
    frameRows = 4'd4;
    pulseFrame();
    vBase = validSeen;
    for (int s = 0; s < 16; s++) begin
      globalTicks = SW'(s);
      pulseFrame();
      globalTicks = SW'((s + 7) % 16);  // must not matter (R5)
      n = ((s == 0) ? 1 : s) * 16;
      @(negedge clk) trigger = 1'b1;
      @(negedge clk) trigger = 1'b0;
      k = 0;
      while (!globalXfer && k < 400) begin
        @(negedge clk);
        k++;
        if (k == 5) trigger = 1'b1;
        else if (k == 6) trigger = 1'b0;
      end
      chk(k == n, "R7 exposure length", k, n);
      @(negedge clk);
      chk(exposureDone == 1 && globalXfer == 0, "R8 done after transfer", int'(exposureDone), 1);
      @(negedge clk);
      chk(exposureDone == 0, "R8 done width", int'(exposureDone), 0);
      xBase = xferSeen;
      for (int r = 0; r < 4; r++) begin
        if (s == 3 && r == 1) trigger = 1'b1;
        pulseRow();
        trigger = 1'b0;
        if (s == 5 && r == 2) begin
          @(negedge clk) trigger = 1'b1;
          @(negedge clk) trigger = 1'b0;
          repeat (100) @(negedge clk);
        end
      end
      if (s == 3 || s == 5) begin
        repeat (70) @(negedge clk);
        chk(xferSeen == xBase, "R9 trigger ignored in readout", xferSeen - xBase, 0);
      end
    end
    chk(validSeen == vBase, "R10 no reset strobes in single", validSeen - vBase, 0);

    finished = 1'b1;
    $display("  %0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule